// File: doc/BRIEF.md
# Morse Letter Flasher

The block flashes one Morse-coded letter, chosen from the eight letters A to H, on a single LED output. A caller sets a 3-bit letter code and pulses a start strobe while the block is idle. The block latches the letter and plays its marks: a short mark (dot) or a long mark (dash), with the LED dark for one unit after each mark. It then raises a one-cycle completion pulse and goes back to idle. A start strobe that arrives while a letter is playing is ignored.

All timing comes from one unit tick, derived from the system clock by a cycle counter. At the default of 25,000,000 cycles on a 50 MHz clock, one unit is half a second. The tick is used only as an enable inside the single clock domain. For fast simulation the unit length is a parameter.

Top module: `morse_flasher`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low), `led_o` and `done_o` are 0, and the block is idle after release.
- R2: `letter_i` selects the pattern, with 000=A, 001=B, 010=C, 011=D, 100=E, 101=F, 110=G and 111=H. The patterns are A .-, B -..., C -.-., D -.., E ., F ..-., G --. and H ...., with marks sent left to right.
- R3: A dot holds `led_o` high for exactly UNIT_CYCLES clock cycles.
- R4: A dash holds `led_o` high for exactly 3*UNIT_CYCLES clock cycles.
- R5: After every mark, `led_o` is low for exactly UNIT_CYCLES cycles before the next mark or before completion.
- R6: When `start_i` is sampled high in idle, `led_o` stays low for the next cycle and rises in the cycle after that.
- R7: While a letter is playing, `start_i` is ignored, and the letter code is taken only at the accepted start, so later changes on `letter_i` have no effect.
- R8: `done_o` is high for exactly one cycle, in the cycle right after the last dark gap ends. In that same cycle the block is idle and can accept a new start.
- R9: Pulling `rst_ni` low during a letter turns `led_o` off at once, and no `done_o` follows for the aborted letter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted in idle only |
| letter_i | input | 3 | Letter code, 000=A through 111=H |
| led_o | output | 1 | LED drive, high during a mark |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a start strobe that lands while a letter is already playing, together with a letter code that changes right after it was accepted. The bench does this for a dash-first letter. It flips `letter_i` in the cycle after acceptance, then strobes start again with a different code in the middle of the sequence. The scoreboard, filled from the original letter only, still has to match every mark and gap. A second hard case is a reset in the middle of a dash. The bench checks that the LED goes dark at once and that no completion pulse appears afterwards.

// File: rtl/morse_pkg.sv
package morse_pkg;
  localparam int unsigned LETTER_W   = 3;
  localparam int unsigned MAX_MARKS  = 4;
  localparam int unsigned IDX_W      = $clog2(MAX_MARKS);
  localparam int unsigned DASH_UNITS = 3;
  localparam int unsigned DASH_CW    = $clog2(DASH_UNITS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DOT,
    ST_DASH,
    ST_GAP
  } seq_state_e;

  // marks[i]: 1 = dot, 0 = dash; mark 0 is sent first
  typedef struct packed {
    logic [MAX_MARKS-1:0] marks;
    logic [IDX_W-1:0]     last_idx;
  } glyph_t;
endpackage

// File: rtl/morse_unit_timer.sv
module morse_unit_timer #(
  parameter int unsigned UNIT_CYCLES = 25_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (UNIT_CYCLES > 2) ? $clog2(UNIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(UNIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CNT_LAST);

  // held at zero outside a timed state so each unit is full length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/morse_glyph_rom.sv
module morse_glyph_rom
  import morse_pkg::*;
(
  input  logic [LETTER_W-1:0] letter_i,
  output glyph_t              glyph_o
);
  always_comb begin
    case (letter_i)
      3'd0:    glyph_o = '{marks: 4'b0001, last_idx: 2'd1}; // .-
      3'd1:    glyph_o = '{marks: 4'b1110, last_idx: 2'd3}; // -...
      3'd2:    glyph_o = '{marks: 4'b1010, last_idx: 2'd3}; // -.-.
      3'd3:    glyph_o = '{marks: 4'b0110, last_idx: 2'd2}; // -..
      3'd4:    glyph_o = '{marks: 4'b0001, last_idx: 2'd0}; // .
      3'd5:    glyph_o = '{marks: 4'b1011, last_idx: 2'd3}; // ..-.
      3'd6:    glyph_o = '{marks: 4'b0100, last_idx: 2'd2}; // --.
      default: glyph_o = '{marks: 4'b1111, last_idx: 2'd3}; // ....
    endcase
  end
endmodule

// File: rtl/morse_seq_fsm.sv
module morse_seq_fsm
  import morse_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  glyph_t     glyph_i,
  input  logic       tick_i,
  output seq_state_e state_o,
  output glyph_t     glyph_q_o,
  output logic       run_o,
  output logic       done_o
);
  seq_state_e          state_q;
  glyph_t              glyph_q;
  logic [IDX_W-1:0]    idx_q;
  logic [IDX_W-1:0]    nxt_idx;
  logic [DASH_CW-1:0]  dash_q;
  logic                done_q;

  assign nxt_idx   = idx_q + 1'b1;
  assign run_o     = (state_q == ST_DOT) || (state_q == ST_DASH) || (state_q == ST_GAP);
  assign state_o   = state_q;
  assign glyph_q_o = glyph_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      glyph_q <= '0;
      idx_q   <= '0;
      dash_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            glyph_q <= glyph_i;
            idx_q   <= '0;
            dash_q  <= '0;
            state_q <= ST_START;
          end
        end
        ST_START: state_q <= glyph_q.marks[0] ? ST_DOT : ST_DASH;
        ST_DOT: if (tick_i) state_q <= ST_GAP;
        ST_DASH: begin
          if (tick_i) begin
            if (dash_q == DASH_CW'(DASH_UNITS - 1)) begin
              dash_q  <= '0;
              state_q <= ST_GAP;
            end else begin
              dash_q <= dash_q + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (tick_i) begin
            if (idx_q == glyph_q.last_idx) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q   <= nxt_idx;
              state_q <= glyph_q.marks[nxt_idx] ? ST_DOT : ST_DASH;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/morse_flasher.sv
module morse_flasher
  import morse_pkg::*;
#(
  parameter int unsigned UNIT_CYCLES = 25_000_000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [LETTER_W-1:0] letter_i,
  output logic                led_o,
  output logic                done_o
);
  glyph_t     rom_glyph;
  glyph_t     glyph_q;
  seq_state_e state_q;
  logic       unit_tick;
  logic       run;

  morse_glyph_rom u_rom (
    .letter_i (letter_i),
    .glyph_o  (rom_glyph)
  );

  morse_unit_timer #(.UNIT_CYCLES(UNIT_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (unit_tick)
  );

  morse_seq_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .glyph_i   (rom_glyph),
    .tick_i    (unit_tick),
    .state_o   (state_q),
    .glyph_q_o (glyph_q),
    .run_o     (run),
    .done_o    (done_o)
  );

  assign led_o = (state_q == ST_DOT) || (state_q == ST_DASH);
endmodule

// File: rtl/morse_flasher_chk.sv
module morse_flasher_chk
  import morse_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       led_o,
  input logic       done_o,
  input logic       tick,
  input seq_state_e state_q,
  input glyph_t     glyph_q
);
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_DONE_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!led_o && !$past(led_o))); // R5

  AST_GLYPH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(glyph_q)); // R7

  AST_LED_ON_UNIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(led_o) |-> ($past(tick) || $past(state_q == ST_START))); // R3

  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=> (state_q == ST_START && !led_o)); // R6
endmodule

bind morse_flasher morse_flasher_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .led_o   (led_o),
  .done_o  (done_o),
  .tick    (unit_tick),
  .state_q (state_q),
  .glyph_q (glyph_q)
);

// File: tb/morse_flasher_tb_top.sv
module morse_flasher_tb_top;
  localparam int U = 4;

  typedef struct {
    int    kind;   // 0 mark, 1 gap, 2 done
    int    len;
    string req;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       start_i;
  logic [2:0] letter_i;
  logic       led_o;
  logic       done_o;

  int   tests_run = 0;
  int   tests_failed = 0;
  bit   finished = 0;
  exp_t sb_q[$];

  always #10 clk_i = ~clk_i;

  morse_flasher #(.UNIT_CYCLES(U)) dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .letter_i (letter_i),
    .led_o    (led_o),
    .done_o   (done_o)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string code_of(int l);
    case (l)
      0: return ".-";
      1: return "-...";
      2: return "-.-.";
      3: return "-..";
      4: return ".";
      5: return "..-.";
      6: return "--.";
      default: return "....";
    endcase
  endfunction

  task automatic take(int kind, int len);
    exp_t e;
    if (sb_q.size() == 0) begin
      chk(0, "R2 unexpected item kind", kind, -1);
      return;
    end
    e = sb_q.pop_front();
    chk(e.kind == kind, {e.req, " kind"}, kind, e.kind);
    if (kind != 2) chk(e.len == len, {e.req, " length"}, len, e.len);
  endtask

  // monitor: measures LED run lengths at negedge
  logic prev_led, prev_done;
  int   run_len;
  bit   in_letter;
  always @(negedge clk_i) begin
    if (rst_ni !== 1'b1) begin
      prev_led = 0; prev_done = 0; run_len = 0; in_letter = 0;
    end else begin
      if (done_o) begin
        if (prev_done) chk(0, "R8 done wider than one cycle", 2, 1);
        take(1, run_len);
        take(2, 0);
        in_letter = 0;
        run_len = 0;
      end else if (led_o != prev_led) begin
        if (prev_led) take(0, run_len);
        else if (in_letter) take(1, run_len);
        in_letter = 1;
        run_len = 1;
      end else begin
        run_len++;
      end
      prev_led = led_o;
      prev_done = done_o;
    end
  end

  task automatic send_letter(int l, bit poke);
    string p;
    p = code_of(l);
    for (int i = 0; i < p.len(); i++) begin
      if (p.getc(i) == ".") sb_q.push_back('{0, U, "R3 dot"});
      else                  sb_q.push_back('{0, 3*U, "R4 dash"});
      sb_q.push_back('{1, U, "R5 gap"});
    end
    sb_q.push_back('{2, 0, "R8 done"});
    @(negedge clk_i); start_i = 1'b1; letter_i = 3'(l);
    @(negedge clk_i); start_i = 1'b0;
    if (poke) letter_i = 3'(~l);
    chk(led_o == 1'b0, "R6 setup cycle dark", int'(led_o), 0);
    @(negedge clk_i);
    chk(led_o == 1'b1, "R6 led rises", int'(led_o), 1);
    if (poke) begin
      repeat (U + 2) @(negedge clk_i);
      start_i = 1'b1; letter_i = 3'((l + 3) % 8); // R7 ignored start
      @(negedge clk_i); start_i = 1'b0;
    end
    for (int n = 0; n < 400 && sb_q.size() != 0; n++) @(negedge clk_i);
    chk(sb_q.size() == 0, "R2 letter completed", sb_q.size(), 0);
  endtask

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; letter_i = '0;
    repeat (3) @(negedge clk_i);
    chk(led_o == 1'b0, "R1 led in reset", int'(led_o), 0);
    chk(done_o == 1'b0, "R1 done in reset", int'(done_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(led_o == 1'b0, "R1 idle after release", int'(led_o), 0);

    for (int l = 0; l < 8; l++) send_letter(l, 1'b0);
    send_letter(1, 1'b1);  // R7
    send_letter(4, 1'b0);

    // R9: reset in the middle of a dash
    @(negedge clk_i); start_i = 1'b1; letter_i = 3'd6;
    @(negedge clk_i); start_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk(led_o == 1'b1, "R9 inside dash", int'(led_o), 1);
    rst_ni = 1'b0;
    #1;
    chk(led_o == 1'b0, "R9 led off at reset", int'(led_o), 0);
    sb_q.delete();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    begin
      int seen;
      seen = 0;
      for (int n = 0; n < 20*U; n++) begin
        @(negedge clk_i);
        if (led_o || done_o) seen++;
      end
      chk(seen == 0, "R9 no activity after abort", seen, 0);
    end
    send_letter(7, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule